// File: doc/BRIEF.md
# Accelerator call/return register block

This block sits between a host processor and a fixed-function compute core. The host writes the core's call arguments into memory-mapped registers, then requests a start. It polls a busy flag, or waits for an interrupt, and reads the core's result back. The host side is a single-cycle 64-bit read/write port with byte addresses and byte enables. Every register is one 64-bit word, and consecutive registers are 8 bytes apart.

The core side is a start/ready/done handshake. The argument registers drive the core's argument buses directly. A one-cycle start pulse launches a call. When the core reports completion, the block captures its 192-bit return value in that same cycle. It then marks the call as finished and raises a maskable interrupt. Arguments and the return value that are wider than one word occupy consecutive words, with the low word at the lowest address.

Top module: `accel_call_regs`

## Requirements
- R1: After reset every mapped word reads zero, the interrupt output is low and no start pulse is issued.
- R2: The word map (byte offsets) is as follows. 0x00 holds busy in bit 0 and is read-only. 0x08 is write-only and reads zero; writing 1 to bit 0 requests a start. 0x10 holds interrupt enable in bit 0. 0x18 holds done in bit 1 (read-only) and interrupt status in bit 0. 0x20, 0x28 and 0x30 hold the return value, low word first, and are read-only. 0x38 holds a 32-bit argument in bits 31:0. 0x40, 0x48 and 0x50 hold a 192-bit argument, low word first. 0x58 holds a 64-bit argument. 0x60 holds an 8-bit argument in bits 7:0. The argument words read back what was written and appear unchanged on the argument output ports.
- R3: Busy reads 1 while a call is in flight or while the core deasserts ready. A start request while busy reads 0 gives exactly one start pulse, sets busy and clears done.
- R4: A start request made while busy reads 1 is ignored and produces no start pulse.
- R5: On a completion pulse from the core during a call, the full return value is captured in that cycle. Busy then clears, and done and interrupt status set. A completion pulse while no call is in flight changes nothing.
- R6: The interrupt output is high exactly when both interrupt enable and interrupt status are 1. It stays high until status is cleared or the enable is written to 0.
- R7: Writing 1 to bit 0 of 0x18 clears interrupt status, and writing 0 has no effect. A completion in the same cycle as a clear leaves status set.
- R8: A write changes only the bytes whose byte-enable bit is set. Byte enable bit n covers data bits 8n+7:8n.
- R9: Reserved bits read zero, and writes to them have no effect. Reads of unmapped or misaligned addresses return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Host write strobe |
| bus_rd_i | input | 1 | Host read strobe |
| bus_addr_i | input | ADDR_W | Host byte address |
| bus_wdata_i | input | 64 | Host write data |
| bus_be_i | input | 8 | Host byte enables |
| bus_rdata_o | output | 64 | Host read data, same cycle as bus_rd_i, zero otherwise |
| core_start_o | output | 1 | One-cycle call start pulse |
| core_ready_i | input | 1 | Core can accept a call |
| core_done_i | input | 1 | Core completion pulse |
| core_result_i | input | RET_W | Core return value, valid with core_done_i |
| arg_a_o | output | ARG_A_W | 32-bit argument |
| arg_b_o | output | ARG_B_W | 192-bit argument |
| arg_c_o | output | ARG_C_W | 64-bit argument |
| arg_d_o | output | ARG_D_W | 8-bit argument |
| irq_o | output | 1 | Completion interrupt |

## Verification
A stuck or lost busy flag shows up within one read. Either the busy word disagrees with the call in flight, or the host sees a second start pulse, or no start pulse at all, on the core port. A wrong done or status register appears at 0x18 and on irq_o as early as the cycle after completion. A capture taken at the wrong cycle leaves the return words different from the value the stub computed from the arguments. A byte-enable or decode fault corrupts a neighbouring argument word, and the exhaustive byte-enable sweep and the unmapped-address sweep read that word back.

// File: rtl/accel_csr_pkg.sv
package accel_csr_pkg;
  localparam int WORD_W = 64;
  localparam int BE_W   = WORD_W / 8;

  // fixed control words (word index = byte offset / 8)
  localparam int IDX_BUSY  = 0;
  localparam int IDX_START = 1;
  localparam int IDX_IE    = 2;
  localparam int IDX_STAT  = 3;
  localparam int IDX_RET0  = 4;
endpackage

// File: rtl/csr_word_reg.sv
module csr_word_reg #(
  parameter int WIDTH = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WIDTH/8-1:0] be_i,
  input  logic [WIDTH-1:0]   wdata_i,
  output logic [WIDTH-1:0]   q_o
);
  localparam int NB = WIDTH / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                byte_q <= '0;
      else if (we_i && be_i[b])   byte_q <= wdata_i[b*8 +: 8];
    end
    assign q_o[b*8 +: 8] = byte_q;

    p_be_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && be_i[b]) |=> $stable(q_o[b*8 +: 8]));
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/call_ctrl.sv
module call_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic clr_req_i,
  input  logic ie_we_i,
  input  logic ie_d_i,
  input  logic core_ready_i,
  input  logic core_done_i,
  output logic busy_o,
  output logic done_o,
  output logic stat_o,
  output logic ie_o,
  output logic irq_o,
  output logic core_start_o,
  output logic cap_o
);
  logic busy_q, done_q, stat_q, ie_q, start_q;
  logic accept;

  assign accept = start_req_i && !busy_q && core_ready_i;
  assign cap_o  = busy_q && core_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stat_q  <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (cap_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      // completion beats a same-cycle clear
      if (cap_o)          stat_q <= 1'b1;
      else if (clr_req_i) stat_q <= 1'b0;
      if (ie_we_i) ie_q <= ie_d_i;
    end
  end

  assign busy_o       = busy_q || !core_ready_i;
  assign done_o       = done_q;
  assign stat_o       = stat_q;
  assign ie_o         = ie_q;
  assign irq_o        = ie_q && stat_q;
  assign core_start_o = start_q;

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> busy_q && !done_q);
  p_no_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !cap_o |=> !core_start_o);
  p_complete_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !busy_q && done_q && stat_q);
  p_stat_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q && !clr_req_i |=> stat_q);
  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_i && !cap_o |=> !stat_q);
endmodule

// File: rtl/accel_call_regs.sv
module accel_call_regs
  import accel_csr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ARG_A_W = 32,
  parameter int ARG_B_W = 192,
  parameter int ARG_C_W = 64,
  parameter int ARG_D_W = 8,
  parameter int RET_W   = 192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [63:0]        bus_wdata_i,
  input  logic [7:0]         bus_be_i,
  output logic [63:0]        bus_rdata_o,
  output logic               core_start_o,
  input  logic               core_ready_i,
  input  logic               core_done_i,
  input  logic [RET_W-1:0]   core_result_i,
  output logic [ARG_A_W-1:0] arg_a_o,
  output logic [ARG_B_W-1:0] arg_b_o,
  output logic [ARG_C_W-1:0] arg_c_o,
  output logic [ARG_D_W-1:0] arg_d_o,
  output logic               irq_o
);
  localparam int IDX_W     = ADDR_W - 3;
  localparam int RET_WORDS = RET_W / WORD_W;
  localparam int B_WORDS   = ARG_B_W / WORD_W;
  localparam int IDX_A     = IDX_RET0 + RET_WORDS;
  localparam int IDX_B     = IDX_A + 1;
  localparam int IDX_C     = IDX_B + B_WORDS;
  localparam int IDX_D     = IDX_C + 1;
  localparam int N_REGS    = IDX_D + 1;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic [N_REGS-1:0] sel;

  assign idx     = bus_addr_i[ADDR_W-1:3];
  assign aligned = (bus_addr_i[2:0] == 3'd0);

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_REGS; i++)
      sel[i] = aligned && (idx == IDX_W'(i));
  end

  // control
  logic busy, done, stat, ie, cap;
  logic start_req, clr_req, ie_we;

  assign start_req = bus_wr_i && sel[IDX_START] && bus_be_i[0] && bus_wdata_i[0];
  assign clr_req   = bus_wr_i && sel[IDX_STAT]  && bus_be_i[0] && bus_wdata_i[0];
  assign ie_we     = bus_wr_i && sel[IDX_IE]    && bus_be_i[0];

  call_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_req_i  (start_req),
    .clr_req_i    (clr_req),
    .ie_we_i      (ie_we),
    .ie_d_i       (bus_wdata_i[0]),
    .core_ready_i (core_ready_i),
    .core_done_i  (core_done_i),
    .busy_o       (busy),
    .done_o       (done),
    .stat_o       (stat),
    .ie_o         (ie),
    .irq_o        (irq_o),
    .core_start_o (core_start_o),
    .cap_o        (cap)
  );

  // argument words
  csr_word_reg #(.WIDTH(ARG_A_W)) u_arg_a (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .we_i  (bus_wr_i && sel[IDX_A]),
    .be_i  (bus_be_i[ARG_A_W/8-1:0]),
    .wdata_i (bus_wdata_i[ARG_A_W-1:0]),
    .q_o   (arg_a_o)
  );

  for (genvar w = 0; w < B_WORDS; w++) begin : g_arg_b
    csr_word_reg #(.WIDTH(WORD_W)) u_word (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .we_i  (bus_wr_i && sel[IDX_B + w]),
      .be_i  (bus_be_i),
      .wdata_i (bus_wdata_i),
      .q_o   (arg_b_o[w*WORD_W +: WORD_W])
    );
  end

  csr_word_reg #(.WIDTH(ARG_C_W)) u_arg_c (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .we_i  (bus_wr_i && sel[IDX_C]),
    .be_i  (bus_be_i[ARG_C_W/8-1:0]),
    .wdata_i (bus_wdata_i[ARG_C_W-1:0]),
    .q_o   (arg_c_o)
  );

  csr_word_reg #(.WIDTH(ARG_D_W)) u_arg_d (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .we_i  (bus_wr_i && sel[IDX_D]),
    .be_i  (bus_be_i[ARG_D_W/8-1:0]),
    .wdata_i (bus_wdata_i[ARG_D_W-1:0]),
    .q_o   (arg_d_o)
  );

  // return value capture
  logic [RET_W-1:0] ret_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ret_q <= '0;
    else if (cap) ret_q <= core_result_i;
  end

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> ret_q == $past(core_result_i));
  p_ret_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(ret_q));

  // read mux
  logic [63:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (sel[IDX_BUSY]) rd_word[0]   = busy;
    if (sel[IDX_IE])   rd_word[0]   = ie;
    if (sel[IDX_STAT]) rd_word[1:0] = {done, stat};
    for (int i = 0; i < RET_WORDS; i++)
      if (sel[IDX_RET0 + i]) rd_word = ret_q[i*WORD_W +: WORD_W];
    if (sel[IDX_A]) rd_word[ARG_A_W-1:0] = arg_a_o;
    for (int i = 0; i < B_WORDS; i++)
      if (sel[IDX_B + i]) rd_word = arg_b_o[i*WORD_W +: WORD_W];
    if (sel[IDX_C]) rd_word[ARG_C_W-1:0] = arg_c_o;
    if (sel[IDX_D]) rd_word[ARG_D_W-1:0] = arg_d_o;
  end

  assign bus_rdata_o = bus_rd_i ? rd_word : '0;

  p_rd_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
endmodule

// File: tb/accel_call_regs_test.sv
module accel_call_regs_test;
  localparam int LAT = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [63:0]  bus_wdata = '0;
  logic [7:0]   bus_be = '0;
  logic [63:0]  bus_rdata;
  logic         core_start, core_ready, core_done;
  logic [191:0] core_result;
  logic [31:0]  arg_a;
  logic [191:0] arg_b;
  logic [63:0]  arg_c;
  logic [7:0]   arg_d;
  logic         irq;

  always #10 clk = ~clk;

  accel_call_regs uut (
    .clk_i (clk), .rst_ni (rst_ni),
    .bus_wr_i (bus_wr), .bus_rd_i (bus_rd), .bus_addr_i (bus_addr),
    .bus_wdata_i (bus_wdata), .bus_be_i (bus_be), .bus_rdata_o (bus_rdata),
    .core_start_o (core_start), .core_ready_i (core_ready),
    .core_done_i (core_done), .core_result_i (core_result),
    .arg_a_o (arg_a), .arg_b_o (arg_b), .arg_c_o (arg_c), .arg_d_o (arg_d),
    .irq_o (irq)
  );

  function automatic logic [191:0] calc(input logic [31:0] a, input logic [191:0] b,
                                        input logic [63:0] c, input logic [7:0] d);
    calc = {b[191:64] ^ {c, c}, b[63:0] + {a, 24'd0, d}};
  endfunction

  // core stub with fixed latency
  logic         stub_run = 1'b0, stub_done = 1'b0, ready_en = 1'b1;
  logic         spur_done = 1'b0;
  logic [3:0]   stub_cnt = '0;
  logic [191:0] stub_res = '0, spur_res = '0;
  int           n_starts = 0;

  always_ff @(posedge clk) begin
    stub_done <= 1'b0;
    if (core_start) begin
      stub_run <= 1'b1;
      stub_cnt <= 4'(LAT);
    end else if (stub_run) begin
      if (stub_cnt == 4'd1) begin
        stub_run  <= 1'b0;
        stub_done <= 1'b1;
        stub_res  <= calc(arg_a, arg_b, arg_c, arg_d);
      end
      stub_cnt <= stub_cnt - 4'd1;
    end
    if (core_start) n_starts <= n_starts + 1;
  end

  assign core_ready  = !stub_run && ready_en;
  assign core_done   = stub_done || spur_done;
  assign core_result = spur_done ? spur_res : stub_res;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [63:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    for (int i = 0; i < 200; i++) begin
      bus_read(8'h00, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  logic [31:0]  sh_a;
  logic [191:0] sh_b, ret_exp;
  logic [63:0]  sh_c;
  logic [7:0]   sh_d;

  task automatic check_args(input string tag);
    logic [63:0] v;
    bus_read(8'h38, v); check(tag, v, {32'd0, sh_a});
    for (int w = 0; w < 3; w++) begin
      bus_read(8'h40 + 8'(w * 8), v); check(tag, v, sh_b[w*64 +: 64]);
    end
    bus_read(8'h58, v); check(tag, v, sh_c);
    bus_read(8'h60, v); check(tag, v, {56'd0, sh_d});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] v, pat;
    logic [191:0] ret_keep;
    int s0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 13; i++) begin
      bus_read(8'(i * 8), v); check("R1 reset word", v, 64'd0);
    end
    check("R1 irq", {63'd0, irq}, 64'd0);
    check("R1 start", {63'd0, core_start}, 64'd0);

    // R8 exhaustive byte-enable sweep on the 64-bit argument
    sh_c = '0;
    for (int be = 0; be < 256; be++) begin
      pat = {8{8'(be)}} ^ 64'hA55A_3CC3_0FF0_9669;
      bus_write(8'h58, pat, 8'(be));
      for (int b = 0; b < 8; b++) if (be[b]) sh_c[b*8 +: 8] = pat[b*8 +: 8];
      bus_read(8'h58, v); check("R8 byte enables", v, sh_c);
    end

    // R2/R9 layout and reserved bits
    bus_write(8'h38, '1, 8'hFF); sh_a = '1;
    bus_write(8'h60, '1, 8'hFF); sh_d = '1;
    for (int w = 0; w < 3; w++) begin
      sh_b[w*64 +: 64] = 64'h1111_2222_3333_4444 * 64'(w + 3);
      bus_write(8'h40 + 8'(w * 8), sh_b[w*64 +: 64], 8'hFF);
    end
    check_args("R2 readback");
    check("R2 port a", {32'd0, arg_a}, {32'd0, sh_a});
    check("R2 port b0", arg_b[63:0], sh_b[63:0]);
    check("R2 port b2", arg_b[191:128], sh_b[191:128]);
    check("R2 port c", arg_c, sh_c);
    check("R2 port d", {56'd0, arg_d}, {56'd0, sh_d});
    bus_read(8'h08, v); check("R2 start word reads zero", v, 64'd0);
    bus_write(8'h10, '1, 8'hFF);
    bus_read(8'h10, v); check("R9 ie reserved", v, 64'd1);
    bus_write(8'h10, 64'd0, 8'hFF);

    // R9 unmapped and misaligned
    for (int i = 13; i < 32; i++) begin
      bus_write(8'(i * 8), '1, 8'hFF);
      bus_read(8'(i * 8), v); check("R9 unmapped read", v, 64'd0);
    end
    bus_write(8'h39, 64'd0, 8'hFF);
    bus_write(8'h0C, 64'd1, 8'hFF);
    bus_read(8'h3C, v); check("R9 misaligned read", v, 64'd0);
    check("R9 no stray start", 64'(n_starts), 64'd0);
    check_args("R9 args untouched");

    // calls
    for (int k = 0; k < 6; k++) begin
      sh_a = 32'h1000_0001 * 32'(k + 1);
      sh_b = {64'hDEAD_0000_0000_0000 + 64'(k), 64'h0F0F_0F0F_0000_0000 | 64'(k * 7),
              64'hFFFF_FFFF_FFFF_FFF0 + 64'(k)};
      sh_c = 64'h0123_4567_89AB_CDEF ^ {8{8'(k)}};
      sh_d = 8'(8'h11 * k + 3);
      bus_write(8'h38, {32'hFFFF_FFFF, sh_a}, 8'hFF);
      for (int w = 0; w < 3; w++) bus_write(8'h40 + 8'(w * 8), sh_b[w*64 +: 64], 8'hFF);
      bus_write(8'h58, sh_c, 8'hFF);
      bus_write(8'h60, {56'hFF, sh_d}, 8'hFF);
      bus_write(8'h10, 64'(k % 2), 8'h01);
      ret_exp = calc(sh_a, sh_b, sh_c, sh_d);

      s0 = n_starts;
      bus_write(8'h08, 64'd1, 8'h01);
      bus_read(8'h00, v); check("R3 busy after start", v, 64'd1);
      bus_read(8'h18, v); check("R3 done cleared", v, 64'd0);
      bus_write(8'h08, 64'd1, 8'hFF);
      wait_idle();
      check("R4 single pulse", 64'(n_starts - s0), 64'd1);
      bus_read(8'h18, v); check("R5 done and status", v, 64'd3);
      for (int w = 0; w < 3; w++) begin
        bus_read(8'h20 + 8'(w * 8), v); check("R5 return word", v, ret_exp[w*64 +: 64]);
      end
      check("R6 irq follows enable", {63'd0, irq}, 64'(k % 2));
      bus_write(8'h18, 64'd0, 8'hFF);
      bus_read(8'h18, v); check("R7 write zero no effect", v, 64'd3);
      if (k % 2 == 1) begin
        bus_write(8'h10, 64'd0, 8'h01);
        check("R6 irq masked", {63'd0, irq}, 64'd0);
        bus_write(8'h10, 64'd1, 8'h01);
        check("R6 irq unmasked", {63'd0, irq}, 64'd1);
      end
      bus_write(8'h18, 64'd1, 8'h01);
      bus_read(8'h18, v); check("R7 status cleared", v, 64'd2);
      check("R6 irq low after clear", {63'd0, irq}, 64'd0);
    end

    // R3 core not ready
    ready_en = 1'b0;
    bus_read(8'h00, v); check("R3 busy when not ready", v, 64'd1);
    s0 = n_starts;
    bus_write(8'h08, 64'd1, 8'h01);
    repeat (3) @(negedge clk);
    check("R4 start ignored when not ready", 64'(n_starts - s0), 64'd0);
    ready_en = 1'b1;
    bus_read(8'h00, v); check("R3 idle when ready", v, 64'd0);

    // R5 completion while idle ignored
    ret_keep = ret_exp;
    spur_res = ~ret_exp;
    spur_done = 1'b1;
    @(negedge clk);
    spur_done = 1'b0;
    for (int w = 0; w < 3; w++) begin
      bus_read(8'h20 + 8'(w * 8), v); check("R5 idle done ignored", v, ret_keep[w*64 +: 64]);
    end
    bus_read(8'h18, v); check("R5 idle status kept", v, 64'd2);

    // R7 clear in the completion cycle
    bus_write(8'h08, 64'd1, 8'h01);
    repeat (6) @(negedge clk);
    bus_write(8'h18, 64'd1, 8'h01);
    wait_idle();
    bus_read(8'h18, v); check("R7 completion beats clear", v, 64'd3);
    check("R6 irq on", {63'd0, irq}, 64'd1);

    summary();
  end
endmodule